// File: doc/BRIEF.md
# Processor Privilege and Interrupt Priority Unit

This unit holds the privilege state of a small processor core: a supervisor flag, a single-step trace flag and a three-bit interrupt priority mask. These sit with an eight-bit user flag byte in a 16-bit status word. The unit watches retiring instructions, external interrupt requests and bus strobes. It decides when the core enters an exception and which vector the exception uses. It also sends a bus function code to an external address decoder, which uses that code to separate supervisor space from user space and program space from data space.

On every exception entry, the unit puts the pre-entry status word on a push port for the status stack, then forces supervisor mode. A return-from-exception instruction supplies the popped word on a restore input in its retire cycle. Only that path and the exception path can move the supervisor flag. Instruction decode, the stack storage and handler code live elsewhere.

Top module: `priv_state_unit`

## Requirements
- R1: A synchronous reset gives status word 0x2700 (supervisor, trace off, mask 7, user byte 0), bus code 110 and no exception pulse. Status word bits: 15 is trace, 13 is supervisor, 10:8 is the mask, 7:0 is the user byte, and the others read 0.
- R2: A retiring software trap with operand n produces one exception with vector 32+n.
- R3: A status write from user mode updates only bits 7:0. If the upper byte of the written value differs from the current upper byte, the upper byte stays unchanged and a privilege-violation exception with vector 8 follows.
- R4: A return in supervisor mode loads the whole status word from the restore input, with reserved bits cleared. A return from user mode is not performed and raises vector 8 instead. Only a return can clear the supervisor bit.
- R5: An interrupt request level above the mask is accepted with vector 24+level, and the mask becomes that level. A request at or below the mask is held off.
- R6: Level 7 is accepted on each rising transition to 7, even when the mask is 7. A held level 7 is not taken again while the mask is 7.
- R7: With trace set before a retiring instruction that is neither trap nor return and raises no violation, a trace exception with vector 9 follows.
- R8: Every exception entry, pulsed on the output for one cycle with its vector, sets supervisor and clears trace. It pushes the status word as it stood after the retiring instruction's own effect.
- R9: Fixed priority: violation, trap, trace, interrupt. A lower event in the same cycle is not taken, and a still-held interrupt is accepted the next cycle.
- R10: Bus codes are registered, using the mode in effect before the edge: data 001 (user) or 101 (supervisor), program 010 or 110. Data wins over program. The cycle of interrupt acceptance drives 111. With no strobe the code holds. Codes 000, 011 and 100 never appear.
- R11: A status write in supervisor mode updates trace, mask and user byte but leaves the supervisor bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | An instruction retires this cycle |
| ret_trap | input | 1 | Retiring instruction is a software trap |
| ret_rte | input | 1 | Retiring instruction is a return from exception |
| ret_wr | input | 1 | Retiring instruction writes the status word |
| wr_word | input | 16 | Value for a status write |
| trap_num | input | TN_W | Trap operand |
| pop_word | input | 16 | Status word popped from the stack for a return |
| irq_level | input | 3 | External interrupt request level, 0 means none |
| fetch_strobe | input | 1 | Program-space bus access this cycle |
| data_strobe | input | 1 | Data-space bus access this cycle |
| sup_mode | output | 1 | Current supervisor flag |
| status_word | output | 16 | Current status word |
| bus_fc | output | 3 | Bus function code |
| exc_take | output | 1 | One-cycle exception entry pulse, also the stack push strobe |
| exc_vector | output | VEC_W | Vector of the exception entered |
| push_word | output | 16 | Status word to push, valid with exc_take |

## Verification
The assertions assume that at most one of trap, return and status write is flagged on a retire. They also assume a level-7 request is sampled low at least once between intended edges, and that a return's restore word is valid in its retire cycle. The stimulus sets at most one retire kind per step. It holds each interrupt level across several steps, and it drops level 7 to 0 for a step before every new non-maskable edge. Same-cycle collisions are created on purpose only between a retire event and an interrupt request.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W = 16;
  localparam int T_POS  = 15;
  localparam int S_POS  = 13;
  localparam int M_HI   = 10;
  localparam int M_LO   = 8;
  localparam int LVL_W  = M_HI - M_LO + 1;

  typedef logic [2:0] fc_t;
  localparam fc_t FC_IACK  = 3'b111;
  localparam fc_t FC_RESET = 3'b110;

  // bus function code: mode bit, program bit, data bit
  function automatic fc_t fc_code(input logic sup, input logic prog);
    return {sup, prog, ~prog};
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic t, input logic s,
                                                  input logic [LVL_W-1:0] mask,
                                                  input logic [7:0] low);
    return {t, 1'b0, s, 2'b00, mask, low};
  endfunction
endpackage

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] mask,
  input  logic             take,
  output logic             want,
  output logic [LVL_W-1:0] lvl
);
  localparam logic [LVL_W-1:0] TOP = '1;

  logic top_prev_q;
  logic nmi_pend_q;
  logic top_now;
  logic top_edge;
  logic nmi;

  assign top_now  = (req_lvl == TOP);
  assign top_edge = top_now && !top_prev_q;
  assign nmi      = nmi_pend_q || top_edge;
  assign want     = (req_lvl > mask) || nmi;
  assign lvl      = nmi ? TOP : req_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      top_prev_q <= top_now;
      nmi_pend_q <= nmi && !take;
    end
  end

  // R6: a top-level edge that was not serviced is still requested next cycle
  a_r6_nmi_kept: assert property (@(posedge clk) disable iff (rst)
    (nmi && !take) |=> want);
endmodule

// File: rtl/psw_exc_pick.sv
module psw_exc_pick #(
  parameter int LVL_W     = 3,
  parameter int TN_W      = 4,
  parameter int VEC_W     = 8,
  parameter int PRIV_VEC  = 8,
  parameter int TRACE_VEC = 9,
  parameter int TRAP_BASE = 32,
  parameter int IRQ_BASE  = 24
) (
  input  logic             priv_err,
  input  logic             trap_hit,
  input  logic             trace_hit,
  input  logic             irq_want,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [TN_W-1:0]  trap_num,
  output logic             take_any,
  output logic             take_irq,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    take_any = 1'b1;
    take_irq = 1'b0;
    vec      = '0;
    if (priv_err) begin
      vec = VEC_W'(PRIV_VEC);
    end else if (trap_hit) begin
      vec = VEC_W'(TRAP_BASE) + VEC_W'(trap_num);
    end else if (trace_hit) begin
      vec = VEC_W'(TRACE_VEC);
    end else if (irq_want) begin
      take_irq = 1'b1;
      vec      = VEC_W'(IRQ_BASE) + VEC_W'(irq_lvl);
    end else begin
      take_any = 1'b0;
    end
  end
endmodule

// File: rtl/psw_fc_gen.sv
module psw_fc_gen
  import psw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sup,
  input  logic fetch,
  input  logic data,
  input  logic iack,
  output fc_t  fc
);
  always_ff @(posedge clk) begin
    if (rst)        fc <= FC_RESET;
    else if (iack)  fc <= FC_IACK;
    else if (data)  fc <= fc_code(sup, 1'b0);
    else if (fetch) fc <= fc_code(sup, 1'b1);
  end

  a_r10_no_reserved: assert property (@(posedge clk) disable iff (rst)
    (fc != 3'b000) && (fc != 3'b011) && (fc != 3'b100));
  a_r10_iack_code: assert property (@(posedge clk) disable iff (rst)
    iack |=> (fc == FC_IACK));
endmodule

// File: rtl/priv_state_unit.sv
module priv_state_unit
  import psw_pkg::*;
#(
  parameter int TN_W      = 4,
  parameter int VEC_W     = 8,
  parameter int PRIV_VEC  = 8,
  parameter int TRACE_VEC = 9,
  parameter int TRAP_BASE = 32,
  parameter int IRQ_BASE  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire,
  input  logic              ret_trap,
  input  logic              ret_rte,
  input  logic              ret_wr,
  input  logic [15:0]       wr_word,
  input  logic [TN_W-1:0]   trap_num,
  input  logic [15:0]       pop_word,
  input  logic [2:0]        irq_level,
  input  logic              fetch_strobe,
  input  logic              data_strobe,
  output logic              sup_mode,
  output logic [15:0]       status_word,
  output logic [2:0]        bus_fc,
  output logic              exc_take,
  output logic [VEC_W-1:0]  exc_vector,
  output logic [15:0]       push_word
);
  logic             t_q, s_q;
  logic [LVL_W-1:0] mask_q;
  logic [7:0]       low_q;
  logic [15:0]      cur_w, post_w, next_w;
  logic             priv_err, trap_hit, trace_hit;
  logic             irq_want, take_any, take_irq;
  logic [LVL_W-1:0] irq_lvl;
  logic [VEC_W-1:0] vec;
  logic             exc_q;
  logic [VEC_W-1:0] vec_q;
  logic [15:0]      push_q;

  assign cur_w = pack_word(t_q, s_q, mask_q, low_q);

  // privilege checks on the retiring instruction
  assign priv_err  = retire && !s_q &&
                     (ret_rte || (ret_wr && (wr_word[15:8] != cur_w[15:8])));
  assign trap_hit  = retire && ret_trap && !priv_err;
  assign trace_hit = retire && t_q && !ret_trap && !ret_rte && !priv_err;

  // status after the instruction's own effect
  always_comb begin
    post_w = cur_w;
    if (retire && ret_rte && s_q)
      post_w = pack_word(pop_word[T_POS], pop_word[S_POS], pop_word[M_HI:M_LO], pop_word[7:0]);
    else if (retire && ret_wr)
      post_w = s_q ? pack_word(wr_word[T_POS], s_q, wr_word[M_HI:M_LO], wr_word[7:0])
                   : {cur_w[15:8], wr_word[7:0]};
  end

  psw_irq_gate #(.LVL_W(LVL_W)) u_gate (
    .clk(clk), .rst(rst), .req_lvl(irq_level), .mask(mask_q),
    .take(take_irq), .want(irq_want), .lvl(irq_lvl)
  );

  psw_exc_pick #(
    .LVL_W(LVL_W), .TN_W(TN_W), .VEC_W(VEC_W), .PRIV_VEC(PRIV_VEC),
    .TRACE_VEC(TRACE_VEC), .TRAP_BASE(TRAP_BASE), .IRQ_BASE(IRQ_BASE)
  ) u_pick (
    .priv_err(priv_err), .trap_hit(trap_hit), .trace_hit(trace_hit),
    .irq_want(irq_want), .irq_lvl(irq_lvl), .trap_num(trap_num),
    .take_any(take_any), .take_irq(take_irq), .vec(vec)
  );

  psw_fc_gen u_fc (
    .clk(clk), .rst(rst), .sup(s_q), .fetch(fetch_strobe),
    .data(data_strobe), .iack(take_irq), .fc(bus_fc)
  );

  assign next_w = take_any
    ? pack_word(1'b0, 1'b1, take_irq ? irq_lvl : post_w[M_HI:M_LO], post_w[7:0])
    : post_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= 1'b0;
      s_q    <= 1'b1;
      mask_q <= '1;
      low_q  <= '0;
      exc_q  <= 1'b0;
      vec_q  <= '0;
      push_q <= '0;
    end else begin
      t_q    <= next_w[T_POS];
      s_q    <= next_w[S_POS];
      mask_q <= next_w[M_HI:M_LO];
      low_q  <= next_w[7:0];
      exc_q  <= take_any;
      if (take_any) begin
        vec_q  <= vec;
        push_q <= post_w;
      end
    end
  end

  assign sup_mode    = s_q;
  assign status_word = cur_w;
  assign exc_take    = exc_q;
  assign exc_vector  = vec_q;
  assign push_word   = push_q;

  // R3: supervisor is only entered together with an exception entry
  a_r3_sup_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_mode) |-> exc_take);
  // R4: supervisor is only left through a return instruction
  a_r4_sup_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sup_mode) |-> $past(retire && ret_rte));
  // R8: exception entry leaves supervisor set and trace clear
  a_r8_entry_state: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> (sup_mode && !status_word[T_POS]));
  // R5: an interrupt entry loads the mask with its level
  a_r5_mask_loaded: assert property (@(posedge clk) disable iff (rst)
    (exc_take && (exc_vector >= VEC_W'(IRQ_BASE)) && (exc_vector < VEC_W'(IRQ_BASE + 8)))
      |-> (status_word[M_HI:M_LO] == LVL_W'(exc_vector - VEC_W'(IRQ_BASE))));
endmodule

// File: tb/priv_state_unit_test.sv
`timescale 1ns/1ps
module priv_state_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire = 0, ret_trap = 0, ret_rte = 0, ret_wr = 0;
  logic [15:0] wr_word = 0, pop_word = 0;
  logic [3:0]  trap_num = 0;
  logic [2:0]  irq_level = 0;
  logic        fetch_strobe = 0, data_strobe = 0;
  logic        sup_mode, exc_take;
  logic [15:0] status_word, push_word;
  logic [2:0]  bus_fc;
  logic [7:0]  exc_vector;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  priv_state_unit uut (
    .clk(clk), .rst(rst), .retire(retire), .ret_trap(ret_trap), .ret_rte(ret_rte),
    .ret_wr(ret_wr), .wr_word(wr_word), .trap_num(trap_num), .pop_word(pop_word),
    .irq_level(irq_level), .fetch_strobe(fetch_strobe), .data_strobe(data_strobe),
    .sup_mode(sup_mode), .status_word(status_word), .bus_fc(bus_fc),
    .exc_take(exc_take), .exc_vector(exc_vector), .push_word(push_word)
  );

  typedef struct {
    logic [15:0] st;
    logic        ex;
    logic [7:0]  vec;
    logic [15:0] push;
    logic [2:0]  fc;
    string       tag;
  } item_t;
  item_t exp_q[$];

  // reference state built from the requirements
  logic m_t, m_s, m_prev7, m_pend;
  logic [2:0] m_mask, m_fc;
  logic [7:0] m_low;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit tr, input bit rt, input bit w,
                      input logic [15:0] wd, input logic [3:0] tn, input logic [15:0] rw,
                      input logic [2:0] irq, input bit f, input bit d, input string tag);
    logic [15:0] cur, post;
    logic edge7, np, want, priv, trc, sync, ex, itake;
    logic [2:0] ilvl;
    logic [7:0] vec;
    item_t it;
    @(negedge clk);
    retire = r; ret_trap = tr; ret_rte = rt; ret_wr = w; wr_word = wd;
    trap_num = tn; pop_word = rw; irq_level = irq; fetch_strobe = f; data_strobe = d;
    cur   = {m_t, 1'b0, m_s, 2'b00, m_mask, m_low};
    edge7 = (irq == 3'd7) && !m_prev7;
    np    = m_pend || edge7;
    want  = (irq > m_mask) || np;
    ilvl  = np ? 3'd7 : irq;
    priv  = r && !m_s && (rt || (w && wd[15:8] != cur[15:8]));
    trc   = r && m_t && !tr && !rt && !priv;
    post  = cur;
    if (r && rt && m_s) post = {rw[15], 1'b0, rw[13], 2'b00, rw[10:8], rw[7:0]};
    else if (r && w)    post = m_s ? {wd[15], 1'b0, 1'b1, 2'b00, wd[10:8], wd[7:0]} : {cur[15:8], wd[7:0]};
    sync  = priv || (r && tr) || trc;
    vec   = priv ? 8'd8 : (r && tr) ? 8'd32 + 8'(tn) : trc ? 8'd9 : 8'd24 + 8'(ilvl);
    ex    = sync || want;
    itake = !sync && want;
    if (itake)  m_fc = 3'b111;
    else if (d) m_fc = {m_s, 2'b01};
    else if (f) m_fc = {m_s, 2'b10};
    if (ex) begin
      m_t = 1'b0; m_s = 1'b1;
      m_mask = itake ? ilvl : post[10:8];
    end else begin
      m_t = post[15]; m_s = post[13]; m_mask = post[10:8];
    end
    m_low   = post[7:0];
    m_pend  = np && !itake;
    m_prev7 = (irq == 3'd7);
    it.st = {m_t, 1'b0, m_s, 2'b00, m_mask, m_low};
    it.ex = ex; it.vec = vec; it.push = post; it.fc = m_fc; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares each cycle's outputs with the queued expectation
  always @(posedge clk) begin
    item_t it;
    #2;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      chk(it.tag, "status", status_word, it.st);
      chk(it.tag, "sup", {15'd0, sup_mode}, {15'd0, it.st[13]});
      chk(it.tag, "exc", {15'd0, exc_take}, {15'd0, it.ex});
      chk(it.tag, "fc", {13'd0, bus_fc}, {13'd0, it.fc});
      if (it.ex) begin
        chk(it.tag, "vector", {8'd0, exc_vector}, {8'd0, it.vec});
        chk(it.tag, "push", push_word, it.push);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_t = 0; m_s = 1; m_mask = 3'd7; m_low = 0; m_prev7 = 0; m_pend = 0; m_fc = 3'b110;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset values
    chk("R1", "status", status_word, 16'h2700);
    chk("R1", "fc", {13'd0, bus_fc}, 16'h0006);
    chk("R1", "exc", {15'd0, exc_take}, 16'h0000);
    chk("R1", "sup", {15'd0, sup_mode}, 16'h0001);
    // R4 supervisor return drops to user
    step(1,0,1,0, 16'h0, 4'd0, 16'h0000, 3'd0, 0,0, "R4");
    // R10 user codes, data wins over program
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 1,0, "R10");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,1, "R10");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 1,1, "R10");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R10");
    // R3 user write: low byte only, then upper-byte attempt
    step(1,0,0,1, 16'h00A5, 4'd0, 16'h0, 3'd0, 0,0, "R3");
    step(1,0,0,1, 16'h2700, 4'd0, 16'h0, 3'd0, 0,0, "R3");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 1,0, "R10");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,1, "R10");
    // R2 trap from user mode
    step(1,0,1,0, 16'h0, 4'd0, 16'h00A5, 3'd0, 0,0, "R4");
    step(1,1,0,0, 16'h0, 4'd5, 16'h0, 3'd0, 0,0, "R2");
    // R11 supervisor write keeps supervisor bit
    step(1,0,0,1, 16'h0300, 4'd0, 16'h0, 3'd0, 0,0, "R11");
    step(1,0,1,0, 16'h0, 4'd0, 16'h0000, 3'd0, 0,0, "R4");
    // R5 interrupt above mask, then lower request held off
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd3, 1,0, "R5");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd3, 0,0, "R5");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd2, 0,0, "R5");
    // R9 trap and interrupt together
    step(1,1,0,0, 16'h0, 4'd1, 16'h0, 3'd5, 0,0, "R9");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd5, 0,0, "R9");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R9");
    // R6 level 7 with mask 7
    step(1,0,0,1, 16'h2700, 4'd0, 16'h0, 3'd0, 0,0, "R11");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd6, 0,0, "R5");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd7, 0,0, "R6");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd7, 0,0, "R6");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R6");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd7, 0,0, "R6");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R6");
    // R7 trace in supervisor, R8 entry clears trace
    step(1,0,0,1, 16'h8000, 4'd0, 16'h0, 3'd0, 0,0, "R11");
    step(1,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R7");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R8");
    // R7 trace in user mode after a return restoring trace
    step(1,0,1,0, 16'h0, 4'd0, 16'h8011, 3'd0, 0,0, "R4");
    step(1,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R7");
    // R9 level-7 edge with a trap in the same cycle
    step(1,1,0,0, 16'h0, 4'd15, 16'h0, 3'd7, 0,0, "R9");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R9");
    // R4 return from user mode is refused
    step(1,0,1,0, 16'h0, 4'd0, 16'h0000, 3'd0, 0,0, "R4");
    step(1,0,1,0, 16'h0, 4'd0, 16'h0000, 3'd0, 0,0, "R4");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 1,0, "R10");
    step(0,0,0,0, 16'h0, 4'd0, 16'h0, 3'd0, 0,0, "R10");
    repeat (3) @(posedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule